// File: doc/BRIEF.md
# Receive Descriptor Ring Manager

This block walks a ring of two-word receive buffer descriptors held in system memory on behalf of a receive data path. A programmed base address and an 11-bit word counter together form the current descriptor pointer. When a frame begins, the manager reads word 0 of the current descriptor. If the buffer is free, its word address is handed to the data path. When the data path closes the buffer, the manager writes the descriptor back as a two-word burst, marks it used, and steps the pointer. The pointer returns to the base on the descriptor's wrap flag, or after the counter has covered 1024 descriptors.

A descriptor that software still owns is handled in one of two ways. On the first buffer of a frame it raises a buffer-not-available condition. On a later buffer of the same frame it drops the frame and counts a resource error. A bus error response or a grant that arrives too late is treated as an overrun. In that case, as in a data-path abort, the buffer currently in use is recovered: it is not written back, the pointer stays on it, and the next frame reuses it. Frame data movement and address filtering belong to other blocks.

Descriptor word 0 holds the buffer word address in bits 31:2, the wrap flag in bit 1 and the used flag in bit 0. Word 1 holds the status word that the data path supplies.

Top module: `rx_desc_ring`

## Requirements
- R1: After reset, mem_req, buf_valid, frame_drop, bna_flag, bna_irq and ovr_irq are 0, rre_count is 0 and cur_ptr is 0.
- R2: cur_ptr always equals the base plus 4 times the word counter. A base_load loads the base with bits 1:0 cleared and zeroes the counter, but only while rx_enable is 0 and no frame is in progress. A base_load while rx_enable is 1 has no effect on cur_ptr.
- R3: A read of word 0 at cur_ptr starts only when rx_enable is 1 and frame_start is seen while idle. If the bit-0 used flag of that word is 0, buf_valid rises with buf_addr equal to the word with bits 1:0 cleared.
- R4: On buf_close the manager writes a two-word burst. The first word goes to cur_ptr and carries the fetched word with bit 0 set to 1. The second word goes to cur_ptr+4 and carries the buf_status value that was captured with buf_close.
- R5: After the second word of a write-back is accepted, cur_ptr returns to the base if bit 1 of the descriptor is set, and otherwise moves on by 8. The counter also returns to 0 after 1024 descriptors.
- R6: If the used flag is 1 on the first buffer of a frame, bna_flag is set and held until bna_clr, and bna_irq and frame_drop pulse once. cur_ptr and rre_count do not change and no buffer is offered.
- R7: If the used flag is 1 on a later buffer of a frame, frame_drop pulses and rre_count rises by 1. bna_flag does not change, buffers already written back keep their used marks, and cur_ptr stays on the owned descriptor.
- R8: buf_abort while a buffer is held causes no memory write and leaves cur_ptr unchanged. The next frame is given the same buffer.
- R9: A mem_err response on any transfer pulses ovr_irq and frame_drop, abandons the frame and leaves cur_ptr unchanged.
- R10: A request that has gone GNT_TIMEOUT cycles without mem_gnt is withdrawn in the next cycle, and ovr_irq and frame_drop pulse.
- R11: buf_close with buf_eof at 0 starts the fetch of the next descriptor as part of the same frame. frame_start is ignored while a frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_enable | input | 1 | Receive enable |
| base_load | input | 1 | Load the descriptor ring base |
| base_value | input | 32 | Ring base address to load |
| cur_ptr | output | 32 | Current descriptor pointer (readback) |
| frame_start | input | 1 | First byte of a frame has arrived |
| buf_valid | output | 1 | A free buffer is held for the data path |
| buf_addr | output | 32 | Start address of the held buffer |
| buf_close | input | 1 | Data path finished the held buffer |
| buf_eof | input | 1 | With buf_close: this buffer ends the frame |
| buf_status | input | 32 | With buf_close: status word to write back |
| buf_abort | input | 1 | Data path error: recover the held buffer |
| frame_drop | output | 1 | One-cycle pulse: manager abandoned the frame |
| bna_flag | output | 1 | Sticky buffer-not-available status |
| bna_clr | input | 1 | Clears bna_flag |
| bna_irq | output | 1 | One-cycle buffer-not-available interrupt |
| ovr_irq | output | 1 | One-cycle overrun interrupt |
| rre_count | output | 8 | Resource error count (saturating) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_gnt |
| mem_gnt | input | 1 | Transfer accepted this cycle |
| mem_err | input | 1 | Bus error response, valid with mem_gnt |

## Verification
The ring walk is driven with single-buffer frames and with multi-buffer frames that cross the wrap flag. This separates the wrap-flag return from the plain 8-byte step. A separate ring of 1024 descriptors with no wrap flag shows that the counter's own rollover brings the pointer back to the base. Owned descriptors are placed both at the start of a frame and in the middle of one, so that the buffer-not-available path and the resource-error path are each shown to fire only in their own case. Aborts, injected bus errors and a grant held back past the limit all show that the held buffer is recovered and reused. A behavioural memory model checks every bus address and write word against the expected pointer sequence, and compares cur_ptr on every clock.

// File: rtl/rdm_pkg.sv
// Package: shared types and descriptor field positions for the receive
// descriptor ring manager. Assumes 32-bit descriptor words.
package rdm_pkg;
    localparam int WORD_W   = 32;
    localparam int USED_BIT = 0;
    localparam int WRAP_BIT = 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_HOLD,
        ST_WB_ADDR,
        ST_WB_STAT
    } rdm_state_e;
endpackage

// File: rtl/rdm_ptr.sv
// Module: rdm_ptr
// Holds the ring base and the word counter. The pointer is the base plus
// four bytes per counted word. Assumes one descriptor spans two words, so a
// step adds 2. The counter wraps naturally after 2**CNT_W words.
module rdm_ptr
    import rdm_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_val,
    input  logic              advance,
    input  logic              wrap,
    output logic [WORD_W-1:0] ptr
);
    localparam int PAD_W = WORD_W - CNT_W - 2;

    logic [WORD_W-1:0] base_q;
    logic [CNT_W-1:0]  cnt_q;

    // Purpose: load the base, or step or wrap the word counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            base_q <= {load_val[WORD_W-1:2], 2'b00};
            cnt_q  <= '0;
        end else if (advance) begin
            cnt_q  <= wrap ? '0 : cnt_q + CNT_W'(2);
        end
    end

    // Purpose: form the byte pointer from base and counter.
    always_comb ptr = base_q + {{PAD_W{1'b0}}, cnt_q, 2'b00};

    a_r5_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !load) |=> $stable(ptr));

    a_r5_wrap_to_base: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && wrap && !load) |=> (ptr == $past(base_q)));
endmodule

// File: rtl/rdm_ctrl.sv
// Module: rdm_ctrl
// Sequencer for one frame: fetches a descriptor, offers a free buffer,
// writes the descriptor back as a two-word burst, and decides on the
// step, recovery and error events. Assumes mem_rdata and mem_err are
// valid only in a cycle where mem_gnt is high.
module rdm_ctrl
    import rdm_pkg::*;
#(
    parameter int GNT_TIMEOUT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_enable,
    input  logic              base_load,
    input  logic              frame_start,
    input  logic              buf_close,
    input  logic              buf_eof,
    input  logic [WORD_W-1:0] buf_status,
    input  logic              buf_abort,
    input  logic [WORD_W-1:0] ptr,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_gnt,
    input  logic              mem_err,
    output logic              ptr_load,
    output logic              ptr_adv,
    output logic              ptr_wrap,
    output logic              buf_valid,
    output logic [WORD_W-1:0] buf_addr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              ev_bna,
    output logic              ev_rre,
    output logic              ev_ovr
);
    localparam int TMR_W = $clog2(GNT_TIMEOUT + 1);

    rdm_state_e        state_q;
    logic              first_q;
    logic              eof_q;
    logic [WORD_W-1:0] desc_q;
    logic [WORD_W-1:0] stat_q;
    logic [TMR_W-1:0]  timer_q;
    logic              timeout;
    logic              bus_err;
    logic              owned;

    // Purpose: drive the memory port from the current state.
    always_comb begin
        mem_req   = (state_q == ST_FETCH) || (state_q == ST_WB_ADDR) ||
                    (state_q == ST_WB_STAT);
        mem_we    = (state_q == ST_WB_ADDR) || (state_q == ST_WB_STAT);
        mem_addr  = (state_q == ST_WB_STAT) ? ptr + WORD_W'(4) : ptr;
        mem_wdata = (state_q == ST_WB_STAT) ? stat_q
                                            : {desc_q[WORD_W-1:1], 1'b1};
    end

    // Purpose: decode the grant outcome into events.
    always_comb begin
        timeout   = mem_req && !mem_gnt && (timer_q == TMR_W'(GNT_TIMEOUT - 1));
        bus_err   = mem_req && mem_gnt && mem_err;
        owned     = (state_q == ST_FETCH) && mem_gnt && !mem_err &&
                    mem_rdata[USED_BIT];
        ev_bna    = owned && first_q;
        ev_rre    = owned && !first_q;
        ev_ovr    = timeout || bus_err;
        ptr_adv   = (state_q == ST_WB_STAT) && mem_gnt && !mem_err;
        ptr_wrap  = desc_q[WRAP_BIT];
        ptr_load  = base_load && !rx_enable && (state_q == ST_IDLE);
        buf_valid = (state_q == ST_HOLD);
        buf_addr  = {desc_q[WORD_W-1:2], 2'b00};
    end

    // Purpose: count cycles that a request waits for its grant.
    always_ff @(posedge clk) begin
        if (!rst_n || !mem_req || mem_gnt || timeout) timer_q <= '0;
        else                                          timer_q <= timer_q + TMR_W'(1);
    end

    // Purpose: frame sequencing state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            first_q <= 1'b0;
            eof_q   <= 1'b0;
            desc_q  <= '0;
            stat_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (rx_enable && frame_start) begin
                        state_q <= ST_FETCH;
                        first_q <= 1'b1;
                    end
                end
                ST_FETCH: begin
                    if (ev_ovr || owned)  state_q <= ST_IDLE;
                    else if (mem_gnt) begin
                        desc_q  <= mem_rdata;
                        state_q <= ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    if (buf_abort) state_q <= ST_IDLE;
                    else if (buf_close) begin
                        stat_q  <= buf_status;
                        eof_q   <= buf_eof;
                        state_q <= ST_WB_ADDR;
                    end
                end
                ST_WB_ADDR: begin
                    if (ev_ovr)       state_q <= ST_IDLE;
                    else if (mem_gnt) state_q <= ST_WB_STAT;
                end
                ST_WB_STAT: begin
                    if (ev_ovr) state_q <= ST_IDLE;
                    else if (mem_gnt) begin
                        state_q <= eof_q ? ST_IDLE : ST_FETCH;
                        first_q <= 1'b0;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    a_r4_burst_second_word: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WB_ADDR && mem_gnt && !mem_err) |=>
        (mem_req && mem_we && mem_addr == $past(mem_addr) + 32'd4));

    a_r6_owned_offers_nothing: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH && mem_gnt && !mem_err && mem_rdata[USED_BIT]) |=>
        (!buf_valid && !mem_req));

    a_r10_timeout_withdraws: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt && timer_q == TMR_W'(GNT_TIMEOUT - 1)) |=> !mem_req);

    a_r10_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
        timer_q < TMR_W'(GNT_TIMEOUT));

    a_r3_fetch_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req && !buf_valid && !rx_enable) |=> !mem_req);
endmodule

// File: rtl/rdm_stat.sv
// Module: rdm_stat
// Turns the sequencer events into registered interrupt pulses, the sticky
// buffer-not-available flag and the saturating resource error count.
// Assumes at most one event per cycle.
module rdm_stat #(
    parameter int RRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_bna,
    input  logic             ev_rre,
    input  logic             ev_ovr,
    input  logic             bna_clr,
    output logic             bna_flag,
    output logic             bna_irq,
    output logic             ovr_irq,
    output logic             frame_drop,
    output logic [RRE_W-1:0] rre_count
);
    localparam logic [RRE_W-1:0] RRE_MAX = '1;

    // Purpose: register event pulses and update the flag and counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bna_flag   <= 1'b0;
            bna_irq    <= 1'b0;
            ovr_irq    <= 1'b0;
            frame_drop <= 1'b0;
            rre_count  <= '0;
        end else begin
            bna_irq    <= ev_bna;
            ovr_irq    <= ev_ovr;
            frame_drop <= ev_bna || ev_rre || ev_ovr;
            if (ev_bna)       bna_flag <= 1'b1;
            else if (bna_clr) bna_flag <= 1'b0;
            if (ev_rre && rre_count != RRE_MAX) rre_count <= rre_count + RRE_W'(1);
        end
    end

    a_r6_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_bna, ev_rre, ev_ovr}));

    a_r6_flag_follows_event: assert property (@(posedge clk) disable iff (!rst_n)
        ev_bna |=> (bna_flag && bna_irq && frame_drop));

    a_r7_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rre && rre_count != RRE_MAX) |=> (rre_count == $past(rre_count) + RRE_W'(1)));
endmodule

// File: rtl/rx_desc_ring.sv
// Module: rx_desc_ring (top)
// Receive descriptor ring manager: connects the pointer, the frame
// sequencer and the status logic. Assumes a word-aligned ring base with
// 2**CNT_W words of memory above it.
module rx_desc_ring
    import rdm_pkg::*;
#(
    parameter int CNT_W       = 11,
    parameter int GNT_TIMEOUT = 16,
    parameter int RRE_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_enable,
    input  logic              base_load,
    input  logic [WORD_W-1:0] base_value,
    output logic [WORD_W-1:0] cur_ptr,
    input  logic              frame_start,
    output logic              buf_valid,
    output logic [WORD_W-1:0] buf_addr,
    input  logic              buf_close,
    input  logic              buf_eof,
    input  logic [WORD_W-1:0] buf_status,
    input  logic              buf_abort,
    output logic              frame_drop,
    output logic              bna_flag,
    input  logic              bna_clr,
    output logic              bna_irq,
    output logic              ovr_irq,
    output logic [RRE_W-1:0]  rre_count,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_gnt,
    input  logic              mem_err
);
    logic ptr_load, ptr_adv, ptr_wrap;
    logic ev_bna, ev_rre, ev_ovr;

    rdm_ptr #(.CNT_W(CNT_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (base_value),
        .advance  (ptr_adv),
        .wrap     (ptr_wrap),
        .ptr      (cur_ptr)
    );

    rdm_ctrl #(.GNT_TIMEOUT(GNT_TIMEOUT)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_enable   (rx_enable),
        .base_load   (base_load),
        .frame_start (frame_start),
        .buf_close   (buf_close),
        .buf_eof     (buf_eof),
        .buf_status  (buf_status),
        .buf_abort   (buf_abort),
        .ptr         (cur_ptr),
        .mem_rdata   (mem_rdata),
        .mem_gnt     (mem_gnt),
        .mem_err     (mem_err),
        .ptr_load    (ptr_load),
        .ptr_adv     (ptr_adv),
        .ptr_wrap    (ptr_wrap),
        .buf_valid   (buf_valid),
        .buf_addr    (buf_addr),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .ev_bna      (ev_bna),
        .ev_rre      (ev_rre),
        .ev_ovr      (ev_ovr)
    );

    rdm_stat #(.RRE_W(RRE_W)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_bna     (ev_bna),
        .ev_rre     (ev_rre),
        .ev_ovr     (ev_ovr),
        .bna_clr    (bna_clr),
        .bna_flag   (bna_flag),
        .bna_irq    (bna_irq),
        .ovr_irq    (ovr_irq),
        .frame_drop (frame_drop),
        .rre_count  (rre_count)
    );

    a_r9_error_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt && mem_err) |=> ($stable(cur_ptr) && !mem_req));
endmodule

// File: tb/test_rx_desc_ring.sv
module test_rx_desc_ring;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_enable = 1'b0, base_load = 1'b0, frame_start = 1'b0;
    logic [31:0] base_value = '0, buf_status = '0;
    logic        buf_close = 1'b0, buf_eof = 1'b0, buf_abort = 1'b0, bna_clr = 1'b0;
    logic [31:0] cur_ptr, buf_addr, mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        buf_valid, frame_drop, bna_flag, bna_irq, ovr_irq;
    logic        mem_req, mem_we;
    logic        gnt_r = 1'b0, err_r = 1'b0;
    logic [7:0]  rre_count;
    wire         mem_gnt = gnt_r;
    wire         mem_err = gnt_r & err_r;

    always #10 clk = ~clk;   // 50 MHz

    rx_desc_ring i_rx_desc_ring (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .base_load(base_load),
        .base_value(base_value), .cur_ptr(cur_ptr), .frame_start(frame_start),
        .buf_valid(buf_valid), .buf_addr(buf_addr), .buf_close(buf_close),
        .buf_eof(buf_eof), .buf_status(buf_status), .buf_abort(buf_abort),
        .frame_drop(frame_drop), .bna_flag(bna_flag), .bna_clr(bna_clr),
        .bna_irq(bna_irq), .ovr_irq(ovr_irq), .rre_count(rre_count),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_gnt(mem_gnt),
        .mem_err(mem_err)
    );

    int n_chk = 0, n_fail = 0;
    logic [31:0] mem [0:4095];
    logic [31:0] model_base = '0, model_ptr = '0, exp_stat = '0;
    int model_cnt = 0, gnt_dly = 0, wc = 0;
    bit err_arm = 1'b0;
    int bna_n = 0, ovr_n = 0, drop_n = 0;

    function automatic int widx(input logic [31:0] a);
        return int'((a >> 2) & 32'hFFF);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory model and pointer reference, evaluated mid-cycle.
    always @(negedge clk) begin
        if (rst_n) chk("R2 cur_ptr", cur_ptr, model_ptr);
        if (bna_irq)    bna_n++;
        if (ovr_irq)    ovr_n++;
        if (frame_drop) drop_n++;
        if (gnt_r) begin gnt_r = 1'b0; err_r = 1'b0; wc = 0; end
        if (mem_req) begin
            if (wc >= gnt_dly) begin
                gnt_r = 1'b1;
                if (err_arm) begin err_r = 1'b1; err_arm = 1'b0; end
                if (!mem_we) begin
                    chk("R3 fetch addr", mem_addr, model_ptr);
                    mem_rdata = mem[widx(mem_addr)];
                end else if (mem_addr == model_ptr) begin
                    chk("R4 word0 data", mem_wdata, {mem[widx(model_ptr)][31:1], 1'b1});
                    if (!err_r) mem[widx(mem_addr)] = mem_wdata;
                end else begin
                    chk("R4 word1 addr", mem_addr, model_ptr + 32'd4);
                    chk("R4 word1 data", mem_wdata, exp_stat);
                    if (!err_r) begin
                        mem[widx(mem_addr)] = mem_wdata;
                        model_cnt = mem[widx(model_ptr)][1] ? 0 : (model_cnt + 2) % 2048;
                        model_ptr = model_base + 32'(model_cnt * 4);
                    end
                end
            end else wc++;
        end else wc = 0;
    end

    task automatic load_base(input logic [31:0] v, input bit expect_take);
        @(negedge clk); base_load = 1'b1; base_value = v;
        @(posedge clk); #1;
        base_load = 1'b0;
        if (expect_take) begin
            model_base = {v[31:2], 2'b00}; model_cnt = 0; model_ptr = model_base;
        end
    endtask

    task automatic set_enable(input logic v);
        @(negedge clk); rx_enable = v;
    endtask

    task automatic pulse_start();
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
    endtask

    task automatic wait_buf(output bit got);
        int d0 = drop_n;
        got = 1'b0;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (buf_valid) begin got = 1'b1; return; end
            if (drop_n != d0) return;
        end
    endtask

    task automatic close_buf(input logic eof, input logic [31:0] st);
        @(negedge clk); buf_close = 1'b1; buf_eof = eof; buf_status = st; exp_stat = st;
        @(negedge clk); buf_close = 1'b0;
    endtask

    task automatic abort_buf();
        @(negedge clk); buf_abort = 1'b1;
        @(negedge clk); buf_abort = 1'b0;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        for (int i = 0; i < 500 && quiet < 3; i++) begin
            @(negedge clk);
            if (!mem_req && !buf_valid) quiet++; else quiet = 0;
        end
    endtask

    // Take one buffer and check its address against the descriptor in the model memory.
    task automatic take_expect(input string tag, output bit got);
        wait_buf(got);
        chk(tag, 32'(got), 32'd1);
        if (got) chk(tag, buf_addr, {mem[widx(model_ptr)][31:2], 2'b00});
    endtask

    localparam logic [31:0] RING = 32'h0000_2000;

    task automatic run_all();
        bit got;
        int b0, o0, d0;
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 mem_req", 32'(mem_req), 0);
        chk("R1 buf_valid", 32'(buf_valid), 0);
        chk("R1 bna_flag", 32'(bna_flag), 0);
        chk("R1 irqs", {30'd0, bna_irq, ovr_irq}, 0);
        chk("R1 frame_drop", 32'(frame_drop), 0);
        chk("R1 rre_count", 32'(rre_count), 0);
        chk("R1 cur_ptr", cur_ptr, 0);
        rst_n = 1'b1;

        for (int i = 0; i < 4096; i++) mem[i] = '0;
        for (int i = 0; i < 4; i++) mem[widx(RING) + 2*i] = 32'h0008_0000 + 32'(i * 128);
        mem[widx(RING) + 6] = mem[widx(RING) + 6] | 32'h2;

        // R2: base load with receive disabled, readback
        load_base(RING | 32'h3, 1'b1);
        @(negedge clk); chk("R2 base readback", cur_ptr, RING);
        set_enable(1'b1);
        // R2: load ignored while enabled
        load_base(32'h0000_3000, 1'b0);
        @(negedge clk); chk("R2 load ignored", cur_ptr, RING);

        // R3/R4/R5: single-buffer frame
        pulse_start();
        take_expect("R3 first buffer", got);
        close_buf(1'b1, 32'h0000_C040);
        wait_idle();
        chk("R4 used bit d0", 32'(mem[widx(RING)][0]), 1);
        chk("R4 status d0", mem[widx(RING) + 1], 32'h0000_C040);
        chk("R5 step 8", cur_ptr, RING + 32'd8);

        // R11/R5: three-buffer frame crossing the wrap flag
        pulse_start();
        take_expect("R11 buf d1", got);
        @(negedge clk); frame_start = 1'b1;      // R11: ignored while busy
        @(negedge clk); frame_start = 1'b0;
        chk("R11 still held", 32'(buf_valid), 1);
        close_buf(1'b0, 32'h0000_4080);
        take_expect("R11 buf d2", got);
        close_buf(1'b0, 32'h0000_0080);
        take_expect("R11 buf d3", got);
        close_buf(1'b1, 32'h0000_8020);
        wait_idle();
        chk("R5 wrap to base", cur_ptr, RING);
        repeat (4) @(negedge clk);
        chk("R11 no extra fetch", 32'(mem_req), 0);

        // R6: owned descriptor on the first buffer
        b0 = bna_n; d0 = drop_n;
        pulse_start();
        wait_buf(got);
        wait_idle();
        chk("R6 no buffer", 32'(got), 0);
        chk("R6 bna_irq once", 32'(bna_n - b0), 1);
        chk("R6 drop once", 32'(drop_n - d0), 1);
        chk("R6 bna_flag", 32'(bna_flag), 1);
        chk("R6 rre unchanged", 32'(rre_count), 0);
        chk("R6 ptr kept", cur_ptr, RING);
        @(negedge clk); bna_clr = 1'b1;
        @(negedge clk); bna_clr = 1'b0;
        chk("R6 flag cleared", 32'(bna_flag), 0);

        // R7: owned descriptor in the middle of a frame
        mem[widx(RING)][0] = 1'b0;
        mem[widx(RING) + 2][0] = 1'b0;
        b0 = bna_n; d0 = drop_n;
        pulse_start();
        take_expect("R7 buf d0", got);
        close_buf(1'b0, 32'h0000_4080);
        take_expect("R7 buf d1", got);
        close_buf(1'b0, 32'h0000_0080);
        wait_buf(got);
        wait_idle();
        chk("R7 no third buffer", 32'(got), 0);
        chk("R7 rre_count", 32'(rre_count), 1);
        chk("R7 drop once", 32'(drop_n - d0), 1);
        chk("R7 bna untouched", {31'd0, bna_flag}, 0);
        chk("R7 no bna irq", 32'(bna_n - b0), 0);
        chk("R7 earlier kept", {30'd0, mem[widx(RING)][0], mem[widx(RING) + 2][0]}, 32'd3);
        chk("R7 ptr on owned", cur_ptr, RING + 32'd16);

        // R8: abort recovers the held buffer
        mem[widx(RING) + 4][0] = 1'b0;
        pulse_start();
        take_expect("R8 buf d2", got);
        abort_buf();
        wait_idle();
        chk("R8 no write", 32'(mem[widx(RING) + 4][0]), 0);
        chk("R8 ptr kept", cur_ptr, RING + 32'd16);
        pulse_start();
        take_expect("R8 reuse d2", got);
        close_buf(1'b1, 32'h0000_C010);
        wait_idle();
        chk("R8 then step", cur_ptr, RING + 32'd24);

        // R9: bus error on fetch
        mem[widx(RING) + 6][0] = 1'b0;
        o0 = ovr_n; d0 = drop_n;
        err_arm = 1'b1;
        pulse_start();
        wait_buf(got);
        wait_idle();
        chk("R9 no buffer", 32'(got), 0);
        chk("R9 ovr once", 32'(ovr_n - o0), 1);
        chk("R9 drop once", 32'(drop_n - d0), 1);
        chk("R9 ptr kept", cur_ptr, RING + 32'd24);

        // R10: grant held back past the limit
        o0 = ovr_n;
        gnt_dly = 40;
        pulse_start();
        wait_buf(got);
        wait_idle();
        chk("R10 no buffer", 32'(got), 0);
        chk("R10 ovr once", 32'(ovr_n - o0), 1);
        chk("R10 ptr kept", cur_ptr, RING + 32'd24);

        // R3/R5: slow but in-time grants, frame on the wrap descriptor
        gnt_dly = 3;
        pulse_start();
        take_expect("R3 slow grant d3", got);
        close_buf(1'b1, 32'h0000_C004);
        wait_idle();
        chk("R5 wrap after slow", cur_ptr, RING);
        gnt_dly = 0;

        // R5: 1024 descriptors without a wrap flag roll the counter over
        set_enable(1'b0);
        for (int i = 0; i < 1024; i++) begin
            mem[widx(RING) + 2*i]     = 32'h0010_0000 + 32'(i * 128);
            mem[widx(RING) + 2*i + 1] = '0;
        end
        load_base(RING, 1'b1);
        set_enable(1'b1);
        for (int i = 0; i < 1024; i++) begin
            pulse_start();
            wait_buf(got);
            close_buf(1'b1, 32'h0000_C000 | 32'(i & 12'hFFF));
            wait_idle();
            if (i == 1022) chk("R5 last entry", cur_ptr, RING + 32'd8184);
        end
        chk("R5 rollover", cur_ptr, RING);
        chk("R5 last used", 32'(mem[widx(RING) + 2046][0]), 1);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                n_fail++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule